// File: doc/BRIEF.md
# Software Interrupt Target Router

This block sits beside the pending-state storage of a small multi-processor interrupt controller, serving up to eight processors. It handles two routing jobs. It decodes the software-interrupt command word that a processor writes to a fixed offset, and turns it into a per-processor "set pending" strobe together with the interrupt ID. It also holds a byte-wide target-processor mask for every shared source, and uses those masks to steer hardware interrupt lines to the processors that should see them.

Every bus access carries the index of the issuing processor on a sideband input. The block uses this index in two ways: to resolve the "everyone but me" and "only me" command filters, and to answer target reads for the private IDs 29 to 31. All outputs are registered. A command or a line edge appears as a strobe that lasts exactly one cycle, in the cycle after it is accepted. The pending storage downstream ORs these strobes into its state.

Top module: `swi_router`

## Requirements
- R1: After reset every target register reads zero, and `sgi_set` and `hw_set` are zero.
- R2: A write to offset 0xF00 is a software-interrupt command. Its ID is taken from bits 9:0 of the write data and appears on `sgi_id` in the cycle after the write.
- R3: With command bits 25:24 = 0, the strobe vector is bits 23:16 of the command, masked to the processors that exist.
- R4: With bits 25:24 = 1, the strobe covers every existing processor except the requester.
- R5: With bits 25:24 = 2, the strobe covers only the requester. It is zero if the requester index names no existing processor.
- R6: With bits 25:24 = 3, the strobe covers every existing processor.
- R7: `sgi_set` is non-zero only in the cycle right after a command write, and only for one cycle.
- R8: Target registers hold one byte per ID, starting at offset 0x800. ID n sits in byte lane n mod 4 of the word at 0x800 + 4·(n div 4). For shared IDs (32 up to NUM_ID-1), a write stores the byte masked to the existing processors, and a later read returns it. Bytes for IDs at or above NUM_ID read zero, and writes to them are ignored.
- R9: Target bytes for IDs 0 to 28 always read zero, whatever was written to them.
- R10: Target bytes for IDs 29 to 31 read as the requesting processor's bit alone, whatever was written to them.
- R11: When hardware line s (the shared ID 32+s) goes from low to high, `hw_set` slice s is driven with that source's target mask for one cycle, in the cycle after the edge is sampled. All other slices stay zero.
- R12: While a hardware line stays high, its `hw_set` slice stays zero after that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | 32-bit word write strobe |
| bus_rd | input | 1 | 32-bit word read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| req_cpu | input | 3 | Index of the processor issuing the access |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, held until the next read |
| hw_line | input | NUM_ID-32 | Hardware lines of the shared sources, bit s is ID 32+s |
| sgi_set | output | NUM_CPU | Per-processor pending-set strobe for the software interrupt |
| sgi_id | output | 10 | Interrupt ID of the last command |
| hw_set | output | (NUM_ID-32)·NUM_CPU | Per-source, per-processor pending-set strobe, slice s is bits s·NUM_CPU upward |

## Verification
A corrupted target byte does not show up as a spurious interrupt. It shows up only when that source's line next rises, as a strobe reaching the wrong processors, or when software reads the register back one cycle after asking. For that reason the bench reads back every word it writes and fires lines on sources with known masks. A wrong filter decode, or a stale strobe register, shows up on `sgi_set` one cycle after the command. A strobe that fails to clear shows up in the cycle after that, so both are checked on consecutive cycles.

// File: rtl/swi_route_pkg.sv
package swi_route_pkg;

    localparam int MAX_CPU     = 8;
    localparam int CPU_IDX_W   = 3;
    localparam int IRQ_ID_W    = 10;
    localparam int PRIV_IDS    = 32;
    localparam int FIXED_FIRST = 29;
    localparam logic [11:0] CMD_OFFSET = 12'hF00;
    localparam logic [1:0]  TGT_REGION = 2'b10;

    typedef enum logic [1:0] {
        FILT_LIST   = 2'd0,
        FILT_OTHERS = 2'd1,
        FILT_SELF   = 2'd2,
        FILT_ALL    = 2'd3
    } filt_e;

    typedef struct packed {
        logic [IRQ_ID_W-1:0] id;
        logic [MAX_CPU-1:0]  mask;
    } swi_cmd_t;

    function automatic logic [MAX_CPU-1:0] self_bit(input logic [CPU_IDX_W-1:0] req);
        return MAX_CPU'(1) << req;
    endfunction

    function automatic logic [MAX_CPU-1:0] filt_mask(
        input filt_e                f,
        input logic [MAX_CPU-1:0]   list,
        input logic [CPU_IDX_W-1:0] req,
        input logic [MAX_CPU-1:0]   all_cpus
    );
        logic [MAX_CPU-1:0] m;
        unique case (f)
            FILT_LIST:   m = list;
            FILT_OTHERS: m = ~self_bit(req);
            FILT_SELF:   m = self_bit(req);
            default:     m = '1;
        endcase
        return m & all_cpus;
    endfunction

    function automatic swi_cmd_t decode_cmd(
        input logic [31:0]          w,
        input logic [CPU_IDX_W-1:0] req,
        input logic [MAX_CPU-1:0]   all_cpus
    );
        swi_cmd_t c;
        c.id   = w[IRQ_ID_W-1:0];
        c.mask = filt_mask(filt_e'(w[25:24]), w[23:16], req, all_cpus);
        return c;
    endfunction

endpackage

// File: rtl/swi_cmd_dec.sv
module swi_cmd_dec
    import swi_route_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic [31:0]          cmd_word,
    input  logic [CPU_IDX_W-1:0] req_cpu,
    output logic [NUM_CPU-1:0]   sgi_set,
    output logic [IRQ_ID_W-1:0]  sgi_id
);
    localparam logic [MAX_CPU-1:0] ALL_CPUS = MAX_CPU'((1 << NUM_CPU) - 1);

    swi_cmd_t cmd_d;
    assign cmd_d = decode_cmd(cmd_word, req_cpu, ALL_CPUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sgi_set <= '0;
            sgi_id  <= '0;
        end else begin
            sgi_set <= cmd_wr ? cmd_d.mask[NUM_CPU-1:0] : '0;
            if (cmd_wr) sgi_id <= cmd_d.id;
        end
    end

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> (sgi_set == '0));

    assert_id_capture_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (sgi_id == $past(cmd_word[IRQ_ID_W-1:0])));

    assert_self_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_word[25:24] == 2'd2) |=> $onehot0(sgi_set));

    assert_others_skip_req_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_word[25:24] == 2'd1) |=>
            ((MAX_CPU'(sgi_set) & self_bit($past(req_cpu))) == '0));

    assert_all_full_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_word[25:24] == 2'd3) |=> (sgi_set == '1));

endmodule

// File: rtl/swi_tgt_regs.sv
module swi_tgt_regs
    import swi_route_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_ID  = 64
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [7:0]                      word_idx,
    input  logic [31:0]                     wdata,
    input  logic [CPU_IDX_W-1:0]            req_cpu,
    output logic [31:0]                     rdata,
    output logic [(NUM_ID-PRIV_IDS)*NUM_CPU-1:0] tgt_flat
);
    localparam int NUM_SHARED = NUM_ID - PRIV_IDS;
    localparam logic [MAX_CPU-1:0] ALL_CPUS = MAX_CPU'((1 << NUM_CPU) - 1);

    for (genvar s = 0; s < NUM_SHARED; s++) begin : g_src
        localparam int ID   = PRIV_IDS + s;
        localparam int LANE = ID % 4;
        localparam logic [7:0] WORD = 8'(ID / 4);
        logic [NUM_CPU-1:0] tgt_q;
        always_ff @(posedge clk) begin
            if (rst)                          tgt_q <= '0;
            else if (wr_en && word_idx == WORD) tgt_q <= wdata[8*LANE +: NUM_CPU];
        end
        assign tgt_flat[s*NUM_CPU +: NUM_CPU] = tgt_q;
    end

    logic [31:0] rd_word;
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < 4; b++) begin
            int id;
            id = int'(word_idx) * 4 + b;
            if (id >= FIXED_FIRST && id < PRIV_IDS)
                rd_word[8*b +: 8] = self_bit(req_cpu) & ALL_CPUS;
            else if (id >= PRIV_IDS && id < NUM_ID)
                rd_word[8*b +: 8] = 8'(tgt_flat[(id - PRIV_IDS)*NUM_CPU +: NUM_CPU]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    assert_low_ids_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && word_idx < 8'd7) |=> (rdata == '0));

    assert_fixed_self_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && word_idx == 8'd7) |=>
            (rdata[31:8] == {3{self_bit($past(req_cpu)) & ALL_CPUS}} && rdata[7:0] == '0));

endmodule

// File: rtl/swi_hw_route.sv
module swi_hw_route #(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SHARED-1:0]           hw_line,
    input  logic [NUM_SHARED*NUM_CPU-1:0]   tgt_flat,
    output logic [NUM_SHARED*NUM_CPU-1:0]   hw_set
);
    logic [NUM_SHARED-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= hw_line;
    end

    for (genvar s = 0; s < NUM_SHARED; s++) begin : g_edge
        logic [NUM_CPU-1:0] set_q;
        always_ff @(posedge clk) begin
            if (rst) set_q <= '0;
            else     set_q <= (hw_line[s] && !line_q[s]) ? tgt_flat[s*NUM_CPU +: NUM_CPU] : '0;
        end
        assign hw_set[s*NUM_CPU +: NUM_CPU] = set_q;

        assert_hw_needs_line_R11: assert property (@(posedge clk) disable iff (rst)
            (set_q != '0) |-> $past(hw_line[s]));

        assert_hw_one_shot_R12: assert property (@(posedge clk) disable iff (rst)
            (set_q != '0) |=> (set_q == '0));
    end

endmodule

// File: rtl/swi_router.sv
module swi_router
    import swi_route_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_ID  = 64
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   bus_wr,
    input  logic                                   bus_rd,
    input  logic [11:0]                            bus_addr,
    input  logic [31:0]                            bus_wdata,
    input  logic [2:0]                             req_cpu,
    output logic [31:0]                            bus_rdata,
    input  logic [NUM_ID-33:0]                     hw_line,
    output logic [NUM_CPU-1:0]                     sgi_set,
    output logic [9:0]                             sgi_id,
    output logic [(NUM_ID-32)*NUM_CPU-1:0]         hw_set
);
    localparam int NUM_SHARED = NUM_ID - PRIV_IDS;

    logic cmd_wr, tgt_sel;
    logic [NUM_SHARED*NUM_CPU-1:0] tgt_flat;

    assign cmd_wr  = bus_wr && (bus_addr == CMD_OFFSET);
    assign tgt_sel = (bus_addr[11:10] == TGT_REGION);

    swi_cmd_dec #(.NUM_CPU(NUM_CPU)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_word (bus_wdata),
        .req_cpu  (req_cpu),
        .sgi_set  (sgi_set),
        .sgi_id   (sgi_id)
    );

    swi_tgt_regs #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_tgt (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && tgt_sel),
        .rd_en    (bus_rd),
        .word_idx (tgt_sel ? bus_addr[9:2] : 8'd0),
        .wdata    (bus_wdata),
        .req_cpu  (req_cpu),
        .rdata    (bus_rdata),
        .tgt_flat (tgt_flat)
    );

    swi_hw_route #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED)) u_hw (
        .clk      (clk),
        .rst      (rst),
        .hw_line  (hw_line),
        .tgt_flat (tgt_flat),
        .hw_set   (hw_set)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (sgi_set == '0 && hw_set == '0 && bus_rdata == '0));

endmodule

// File: tb/test_swi_router.sv
module test_swi_router;
    localparam int NCPU = 4;
    localparam int NID  = 64;
    localparam int NSH  = NID - 32;

    logic clk = 0, rst = 1;
    logic bus_wr = 0, bus_rd = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  req_cpu = '0;
    logic [31:0] bus_rdata;
    logic [NSH-1:0] hw_line = '0;
    logic [NCPU-1:0] sgi_set;
    logic [9:0] sgi_id;
    logic [NSH*NCPU-1:0] hw_set;

    int checks = 0, fails = 0;
    logic [NCPU-1:0] tgt_m [NSH];

    always #5 clk = ~clk;

    swi_router #(.NUM_CPU(NCPU), .NUM_ID(NID)) i_swi_router (.*);

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [NCPU-1:0] exp_sgi(input logic [31:0] w, input logic [2:0] rq);
        logic [7:0] s = 8'(1) << rq;
        logic [7:0] m;
        case (w[25:24])
            2'd0: m = w[23:16];
            2'd1: m = ~s;
            2'd2: m = s;
            default: m = 8'hFF;
        endcase
        return m[NCPU-1:0];
    endfunction

    function automatic logic [31:0] exp_word(input int wi, input logic [2:0] rq);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            int id = wi * 4 + b;
            if (id >= 29 && id < 32) r[8*b +: 8] = 8'((8'(1) << rq) & 8'h0F);
            else if (id >= 32 && id < NID) r[8*b +: 8] = 8'(tgt_m[id-32]);
        end
        return r;
    endfunction

    task automatic wr_tgt(input int wi, input logic [31:0] d, input logic [2:0] rq);
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'h800 + 12'(wi*4); bus_wdata = d; req_cpu = rq;
        @(negedge clk);
        bus_wr = 0;
        for (int b = 0; b < 4; b++)
            if (wi*4+b >= 32 && wi*4+b < NID) tgt_m[wi*4+b-32] = d[8*b +: NCPU];
    endtask

    task automatic rd_tgt(input string rq, input int wi, input logic [2:0] r);
        @(negedge clk);
        bus_rd = 1; bus_addr = 12'h800 + 12'(wi*4); req_cpu = r;
        @(negedge clk);
        bus_rd = 0;
        chk(rq, bus_rdata, exp_word(wi, r));
    endtask

    task automatic sgi(input string rq, input logic [31:0] w, input logic [2:0] r);
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'hF00; bus_wdata = w; req_cpu = r;
        @(negedge clk);
        bus_wr = 0;
        chk(rq, sgi_set, exp_sgi(w, r));
        chk("R2", sgi_id, w[9:0]);
        @(negedge clk);
        chk("R7", sgi_set, '0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < NSH; i++) tgt_m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", sgi_set, '0);
        chk("R1", hw_set, '0);
        rd_tgt("R1", 8, 3'd0);
        rd_tgt("R1", 15, 3'd0);
        // R9: low IDs ignore writes
        wr_tgt(2, 32'hFFFF_FFFF, 3'd1);
        rd_tgt("R9", 2, 3'd1);
        // R10: IDs 29..31 give requester bit
        wr_tgt(7, 32'hFFFF_FFFF, 3'd0);
        rd_tgt("R10", 7, 3'd2);
        rd_tgt("R10", 7, 3'd3);
        // R8: masking and out-of-range
        wr_tgt(9, 32'hA5C3_F05A, 3'd0);
        rd_tgt("R8", 9, 3'd0);
        wr_tgt(16, 32'hFFFF_FFFF, 3'd0);
        rd_tgt("R8", 16, 3'd0);
        // directed filters
        sgi("R3", 32'h00F5_0123, 3'd0);
        sgi("R4", 32'h0100_0007, 3'd2);
        sgi("R5", 32'h0200_03FF, 3'd3);
        sgi("R5", 32'h0200_0011, 3'd6);
        sgi("R6", 32'h0300_0002, 3'd1);
        // R11/R12 hardware routing: source 5 (ID 37) has a known mask
        wr_tgt(9, 32'h0000_0600, 3'd0);  // ID 37 -> 0110
        @(negedge clk);
        hw_line[5] = 1; hw_line[6] = 1;
        @(negedge clk);
        chk("R11", hw_set, (128'(tgt_m[5]) << (5*NCPU)) | (128'(tgt_m[6]) << (6*NCPU)));
        @(negedge clk);
        chk("R12", hw_set, '0);
        hw_line = '0;
        @(negedge clk);
        chk("R12", hw_set, '0);
        // random mix
        for (int i = 0; i < 60; i++) begin
            int op = $urandom_range(0, 3);
            logic [2:0] r = 3'($urandom_range(0, 7));
            if (op == 0) wr_tgt($urandom_range(8, 17), $urandom, r);
            else if (op == 1) rd_tgt("R8", $urandom_range(0, 17), r);
            else if (op == 2) begin
                logic [31:0] w = $urandom;
                string rq;
                case (w[25:24]) 2'd0: rq = "R3"; 2'd1: rq = "R4"; 2'd2: rq = "R5"; default: rq = "R6"; endcase
                sgi(rq, w, r);
            end else begin
                int s = $urandom_range(0, NSH-1);
                logic [127:0] e;
                @(negedge clk);
                hw_line[s] = 1;
                e = 128'(tgt_m[s]) << (s*NCPU);
                @(negedge clk);
                chk("R11", hw_set, e);
                hw_line[s] = 0;
                @(negedge clk);
                chk("R11", hw_set, '0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule